// File: doc/BRIEF.md
# Width-Splitting Posted Write Buffer

This block sits between a processor store port and an external memory bus. Stores are posted: each one (address, data, byte enables) enters a small first-in first-out queue in one cycle, and the processor is held off only while the queue is full. The oldest entry is written out at whatever pace the memory acknowledges, so write-through stores do not wait for slow memory.

Memory regions may be 8, 16 or 32 bits wide. The block shows the address of the oldest entry on a lookup output, and the system returns that region's port width on the same cycle. A store to a narrow port is cut into byte or halfword bus writes. Each narrow write carries its data in the low lanes and has its own address. The store issuer never sees this. An empty flag lets a read path wait until all posted writes have drained.

Top module: `wb_posted_splitter`

## Requirements
- R1: While fewer than four entries are held, `st_ready` is high and a store with `st_valid` high is captured at that clock edge; after four captured stores with no retirement, `full` is high and `st_ready` is low.
- R2: Stores are written to the bus in the order they were captured, and every piece of an older store comes before any piece of a younger one.
- R3: A store offered while `full` is high is not captured and causes no bus transaction.
- R4: Width code 2'b10 or 2'b11 on `lk_width` means a 32-bit port: the store goes out as one transaction at the word-aligned address (`addr` with bits [1:0] cleared), with data unchanged and `bus_be` equal to the stored enables.
- R5: Width code 2'b01 means a 16-bit port: each halfword with at least one enable set goes out as one transaction, the lower half first, at word address +0 or +2. The halfword sits in `bus_data[15:0]` with the upper bits zero, and `bus_be[1:0]` holds that half's enables with `bus_be[3:2]` zero.
- R6: Width code 2'b00 means an 8-bit port: each enabled byte k goes out as one transaction in ascending k, at word address +k, with the byte in `bus_data[7:0]`, the upper bits zero, and `bus_be` = 4'b0001.
- R7: While `bus_req` is high and `bus_ack` is low, the request and `bus_addr`, `bus_data`, `bus_be` keep their values into the next cycle.
- R8: An entry leaves the queue only after its last piece is acknowledged. `empty` stays low while any piece is still outstanding and goes high once every entry has been retired.
- R9: A store with all byte enables clear is retired without any bus transaction.
- R10: The cycle after reset is sampled low, `empty` is high, `full` is low and `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store offered |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 32 | Store data, lane k = byte k of the word |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store will be captured at this edge |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry pending |
| lk_addr | output | ADDR_W | Address of the oldest entry, for the width lookup |
| lk_width | input | 2 | Port width of that region: 00=8, 01=16, else 32 |
| bus_req | output | 1 | Write transaction requested |
| bus_addr | output | ADDR_W | Transaction byte address |
| bus_data | output | 32 | Transaction data, narrow data in low lanes |
| bus_be | output | 4 | Transaction byte enables |
| bus_ack | input | 1 | Memory accepts the transaction at this edge |

## Verification
The assertions check the per-cycle rules on every cycle: requests stay stable until acknowledged, narrow transactions use the correct lanes and alignment for the current width, a request never appears while the queue reports empty, and reset leaves the outputs in their idle state. Order across entries, the exact piece sequence of each store, skipping of empty halves and bytes, discarding of stores without enables, and refusal of stores while full are properties of whole scenarios. Only the bench's reference model can show these, because it compares every acknowledged transaction with the pieces it expects.

// File: rtl/wb_pkg.sv
// Package: shared encodings for the posted write buffer.
// Assumes a 32-bit store datum with four byte lanes.
package wb_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    // Port-width code returned by the region lookup.
    typedef enum logic [1:0] {
        PW_8  = 2'b00,
        PW_16 = 2'b01,
        PW_32 = 2'b10,
        PW_32B = 2'b11
    } pw_e;
endpackage

// File: rtl/wb_fifo.sv
// Module: wb_fifo
// Small FIFO of opaque words. Push is ignored while full, and pop is only
// issued while not empty. Storage is not reset; only the pointers are.
module wb_fifo #(
    parameter int WIDTH = 68,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign rdata   = mem[rd_ptr];

    // Write the new entry into storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wb_split_sel.sv
// Module: wb_split_sel
// Chooses the next piece of a store from its enables, the lanes already
// written and the port width. Purely combinational; assumes four lanes.
module wb_split_sel
    import wb_pkg::*;
(
    input  logic [LANES-1:0] be,
    input  logic [LANES-1:0] done,
    input  pw_e              width,
    output logic [LANES-1:0] mask,
    output logic [OFF_W-1:0] off,
    output logic             has_work,
    output logic             last
);
    logic [LANES-1:0] rem;
    logic [OFF_W-1:0] low_byte;

    assign rem      = be & ~done;
    assign has_work = |rem;
    assign last     = ((rem & ~mask) == '0);

    // Find the lowest lane still to be written.
    always_comb begin
        low_byte = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (rem[i]) low_byte = OFF_W'(i);
        end
    end

    // Build the lane mask and byte offset of the next piece.
    always_comb begin
        case (width)
            PW_8: begin
                mask = LANES'(1) << low_byte;
                off  = low_byte;
            end
            PW_16: begin
                if (|rem[1:0]) begin
                    mask = rem & 4'b0011;
                    off  = 2'd0;
                end else begin
                    mask = rem & 4'b1100;
                    off  = 2'd2;
                end
            end
            default: begin
                mask = rem;
                off  = '0;
            end
        endcase
    end
endmodule

// File: rtl/wb_posted_splitter.sv
// Module: wb_posted_splitter
// Posted write buffer. Captures stores in one cycle and retires the oldest
// as one or more bus writes sized to the region's port width.
// Assumes lk_width is a function of the address region, stable while an
// entry is retired, and that the memory samples bus_ack on the clock edge.
module wb_posted_splitter
    import wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [LANES-1:0]  st_be,
    output logic              st_ready,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic [1:0]        lk_width,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic [LANES-1:0]  bus_be,
    input  logic              bus_ack
);
    localparam int ENT_W = ADDR_W + DATA_W + LANES;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } entry_t;

    entry_t           head, in_ent;
    logic [ENT_W-1:0] head_bits;
    logic [LANES-1:0] done_q, piece_mask;
    logic [OFF_W-1:0] piece_off;
    logic             has_work, piece_last, pop;
    pw_e              width;
    logic [DATA_W-1:0] shifted;

    assign in_ent   = '{addr: st_addr, data: st_data, be: st_be};
    assign st_ready = !full;
    assign head     = entry_t'(head_bits);
    assign lk_addr  = head.addr;
    assign width    = pw_e'(lk_width);

    wb_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (st_valid),
        .wdata (ENT_W'(in_ent)),
        .pop   (pop),
        .rdata (head_bits),
        .full  (full),
        .empty (empty)
    );

    wb_split_sel u_sel (
        .be       (head.be),
        .done     (done_q),
        .width    (width),
        .mask     (piece_mask),
        .off      (piece_off),
        .has_work (has_work),
        .last     (piece_last)
    );

    assign bus_req = !empty && has_work;
    assign pop     = !empty && (!has_work || (bus_ack && piece_last));

    // Drive the piece address, low-lane data and lane enables.
    always_comb begin
        shifted  = head.data >> {piece_off, 3'b000};
        bus_addr = {head.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                   + ADDR_W'(piece_off);
        bus_be   = piece_mask >> piece_off;
        case (width)
            PW_8:    bus_data = shifted & DATA_W'(8'hFF);
            PW_16:   bus_data = shifted & DATA_W'(16'hFFFF);
            default: bus_data = shifted;
        endcase
    end

    // Record the lanes already written for the head entry.
    always_ff @(posedge clk) begin
        if (!rst_n || pop)
            done_q <= '0;
        else if (bus_req && bus_ack)
            done_q <= done_q | piece_mask;
    end
endmodule

// File: rtl/wb_checker.sv
// Module: wb_checker
// Cycle-level properties of the posted write buffer, bound to the top.
module wb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full,
    input logic              empty,
    input logic [1:0]        lk_width,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_data,
    input logic [3:0]        bus_be,
    input logic              bus_ack
);
    // R10: idle outputs after reset.
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !bus_req));

    // R7: unacknowledged requests stay put.
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_data) && $stable(bus_be)));

    // R6: byte port pieces use lane 0 only.
    assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && lk_width == 2'b00) |-> (bus_be == 4'b0001
                                            && bus_data[31:8] == '0));

    // R5: halfword port pieces use the low half, halfword aligned.
    assert_half_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && lk_width == 2'b01) |-> (bus_be[3:2] == 2'b00
                                            && bus_data[31:16] == '0
                                            && bus_addr[0] == 1'b0));

    // R4: word port writes are word aligned.
    assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && lk_width[1]) |-> (bus_addr[1:0] == 2'b00));

    // R8: a pending transaction means the queue is not empty.
    assert_req_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !empty);

    // R1: full and empty never coincide.
    assert_full_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind wb_posted_splitter wb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .empty    (empty),
    .lk_width (lk_width),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_be   (bus_be),
    .bus_ack  (bus_ack)
);

// File: tb/tb_wb_posted_splitter.sv
// Bench: reference model of expected bus pieces, directed cases and
// seeded random traffic with a randomly slow memory.
module tb_wb_posted_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_ready, full, empty, bus_req, bus_ack = 1'b0;
    logic [31:0] lk_addr, bus_addr, bus_data;
    logic [1:0]  lk_width;
    logic [3:0]  bus_be;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [67:0] exp_q[$];
    bit          hold_pend = 0;
    logic [67:0] hold_val;

    always #5 clk = ~clk;

    // Region map: top nibble 0 = 8-bit, 1 = 16-bit, otherwise 32-bit.
    function automatic logic [1:0] region_width(input logic [31:0] a);
        case (a[31:28])
            4'h0:    return 2'b00;
            4'h1:    return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    assign lk_width = region_width(lk_addr);

    wb_posted_splitter dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_ready(st_ready), .full(full),
        .empty(empty), .lk_addr(lk_addr), .lk_width(lk_width),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_be(bus_be), .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string req,
                         input logic [67:0] act, input logic [67:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Append the expected pieces of one captured store (R4, R5, R6, R9).
    task automatic model_store(input logic [31:0] a, input logic [31:0] d,
                               input logic [3:0] be);
        logic [31:0] base;
        base = {a[31:2], 2'b00};
        case (region_width(a))
            2'b00: for (int k = 0; k < 4; k++)
                if (be[k]) exp_q.push_back({base + 32'(k), {24'h0, d[8*k +: 8]}, 4'b0001});
            2'b01: for (int h = 0; h < 2; h++)
                if (be[2*h +: 2] != 2'b00)
                    exp_q.push_back({base + 32'(2*h), {16'h0, d[16*h +: 16]},
                                     {2'b00, be[2*h +: 2]}});
            default: if (be != 4'b0000) exp_q.push_back({base, d, be});
        endcase
    endtask

    // One cycle at the falling edge: observe, then drive for the next edge.
    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input bit ack_en);
        logic [67:0] cur, exp;
        cur = {bus_addr, bus_data, bus_be};
        if (hold_pend)
            check(bus_req && cur == hold_val, "R7 hold", cur, hold_val);
        if (exp_q.size() > 0)
            check(!empty, "R8 empty while pending", {67'h0, empty}, 68'h0);
        if (bus_req && ack_en) begin
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : 68'hx;
            check(cur === exp, "R2/R4/R5/R6 piece", cur, exp);
        end
        hold_pend = bus_req && !ack_en;
        hold_val  = cur;
        bus_ack  = bus_req && ack_en;
        st_valid = v;
        st_addr  = a;
        st_data  = d;
        st_be    = be;
        if (v && st_ready) model_store(a, d, be);
        @(negedge clk);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (exp_q.size() == 0 && empty) break;
            step(0, 32'h0, 32'h0, 4'h0, 1);
        end
        step(0, 32'h0, 32'h0, 4'h0, 1);
        check(exp_q.size() == 0, "R8 all pieces seen", 68'(exp_q.size()), 68'h0);
        check(empty && !bus_req, "R8 empty after drain", {66'h0, empty, bus_req}, 68'h2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd2024));
        @(negedge clk);
        @(negedge clk);
        // R10: idle after reset.
        check(empty && !full && !bus_req && st_ready, "R10 reset",
              {64'h0, empty, full, bus_req, st_ready}, 68'h9);
        rst_n = 1'b1;

        // R4: 32-bit region, single piece.
        step(1, 32'h2000_0107, 32'hA1B2_C3D4, 4'b1111, 1);
        // R5: 16-bit region, partial enables on both halves.
        step(1, 32'h1000_0040, 32'h1122_3344, 4'b0110, 1);
        // R5: upper half only, lower half skipped.
        step(1, 32'h1000_0080, 32'h5566_7788, 4'b1100, 1);
        // R6: 8-bit region, bytes 0, 1, 3.
        step(1, 32'h0000_0010, 32'hDEAD_BEEF, 4'b1011, 1);
        drain(50);

        // R9: no enables, no transaction.
        step(1, 32'h0000_0020, 32'hFFFF_FFFF, 4'b0000, 1);
        step(0, 32'h0, 32'h0, 4'h0, 1);
        check(!bus_req, "R9 no transaction", {67'h0, bus_req}, 68'h0);
        step(0, 32'h0, 32'h0, 4'h0, 1);
        check(empty, "R9 retired", {67'h0, empty}, 68'h1);

        // R1/R3: fill with memory stalled, fifth store refused.
        for (int i = 0; i < 4; i++)
            step(1, 32'h0000_0100 + 32'(4*i), 32'h0101_0101 * 32'(i + 1), 4'b1111, 0);
        check(full && !st_ready, "R1 full after four",
              {66'h0, full, st_ready}, 68'h2);
        step(1, 32'h2000_0F00, 32'hBAD0_BAD0, 4'b1111, 0);
        step(0, 32'h0, 32'h0, 4'h0, 0);
        check(full, "R3 still full", {67'h0, full}, 68'h1);
        drain(200);

        // Random traffic with a slow memory.
        for (int i = 0; i < 3000; i++) begin
            case ($urandom_range(0, 3))
                0:       a = {4'h0, 28'($urandom)};
                1:       a = {4'h1, 28'($urandom)};
                2:       a = {4'h2, 28'($urandom)};
                default: a = {4'h8, 28'($urandom)};
            endcase
            step($urandom_range(0, 9) < 6, a, $urandom, 4'($urandom),
                 $urandom_range(0, 1) == 1);
        end
        drain(500);
        summary();
    end
endmodule